// File: doc/BRIEF.md
# Signed Double-Width Integer Divider

This block divides a signed dividend of twice the operand width by a signed divisor of the operand width. It returns a quotient and a remainder, each of operand width. The dividend arrives as two operand-width halves, with the high half above the low half. A two-bit size select picks an operand width of 8, 16, 32 or 64 bits. The block reports a divide error whenever the signed quotient does not fit the chosen width, and also when the divisor is zero.

An operation starts with a one-cycle `start_i` while the block is idle. The block strips the signs and runs one restoring shift-subtract step per clock, one step for each operand bit. It then restores the signs, checks the result against the signed range and pulses `done_o`. On error the previous quotient and remainder stay on the outputs. For the 8-bit size the two results are also offered as one 16-bit word, in the layout a byte-wide accumulator pair expects.

Top module: `sdiv_top`

## Requirements
- R1: `size_i` selects the operand width W: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The dividend is the 2W-bit two's-complement value {`dvd_hi_i[W-1:0]`, `dvd_lo_i[W-1:0]`` and the divisor is `dvs_i[W-1:0]`. Input bits at or above W are ignored.
- R2: The quotient is the exact quotient truncated toward zero.
- R3: The remainder equals dividend minus quotient times divisor. It is either zero or carries the dividend's sign, and its magnitude is below the divisor's magnitude.
- R4: When the true quotient is above 2^(W-1)-1 or below -2^(W-1), `div_err_o` is high in the `done_o` cycle, and `quo_o` and `rem_o` keep their previous values. A quotient of exactly -2^(W-1) is not an error.
- R5: A zero divisor raises `div_err_o` in the `done_o` cycle and leaves `quo_o` and `rem_o` unchanged.
- R6: `pack_o` is {`rem_o[7:0]`, `quo_o[7:0]`}, so the remainder sits in the high byte and the quotient in the low byte.
- R7: `done_o` is a single-cycle pulse. It comes W+1 clock edges after the edge that accepted `start_i`. `busy_o` is high from the accepting edge until that pulse, and is low while `done_o` is high.
- R8: `start_i` is ignored while `busy_o` is high. Operands presented then have no effect on the result in progress.
- R9: After reset the block is idle, and `busy_o`, `done_o`, `div_err_o`, `quo_o`, `rem_o` and `pack_o` are all zero.
- R10: `quo_o` and `rem_o` hold the W-bit results sign-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only while idle) |
| size_i | input | 2 | Operand width select |
| dvd_hi_i | input | 64 | Upper half of the dividend |
| dvd_lo_i | input | 64 | Lower half of the dividend |
| dvs_i | input | 64 | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Divide error, valid with `done_o` |
| quo_o | output | 64 | Quotient, sign-extended |
| rem_o | output | 64 | Remainder, sign-extended |
| pack_o | output | 16 | Remainder high byte, quotient low byte |

## Verification
The four sign combinations of a small division are run at the 8-bit and 64-bit sizes. They separate truncation toward zero from flooring, and show that the remainder follows the dividend's sign rather than the divisor's.

Boundary dividends are chosen to land exactly on the positive and negative limits of the signed range, and one step beyond each. A zero divisor and the most negative 128-bit dividend are also included. Together these separate a correct overflow test from an off-by-one test and from a test that checks only the high half.

Random operands at all sizes carry junk in the bits above the chosen width, which exposes any leak of unused input bits. A second `start_i` raised mid-operation with different operands confirms that busy requests are dropped.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_e;

  // operand width for a size code: 8 << code
  function automatic int unsigned op_bits(input int unsigned sel);
    return 32'd8 << sel;
  endfunction
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep
  import sdiv_pkg::*;
#(
  parameter int unsigned NUM_SZ = 4,
  parameter int unsigned MAX_W  = 64,
  parameter int unsigned SZW    = 2
) (
  input  logic [SZW-1:0]   sz_i,
  input  logic [MAX_W-1:0] hi_i,
  input  logic [MAX_W-1:0] lo_i,
  input  logic [MAX_W-1:0] dvs_i,
  output logic [MAX_W-1:0] r0_o,
  output logic [MAX_W-1:0] q0_o,
  output logic [MAX_W-1:0] dmag_o,
  output logic             dvd_neg_o,
  output logic             dvs_neg_o,
  output logic             pre_err_o
);
  localparam int unsigned DW = 2 * MAX_W;

  logic [DW-1:0]    dvd_ext [NUM_SZ];
  logic [MAX_W-1:0] dvs_ext [NUM_SZ];

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
    localparam int unsigned W = 8 << s;
    logic [2*W-1:0] joined;
    assign joined     = {hi_i[W-1:0], lo_i[W-1:0]};
    assign dvd_ext[s] = DW'($signed(joined));
    assign dvs_ext[s] = MAX_W'($signed(dvs_i[W-1:0]));
  end

  logic [DW-1:0]    dvd_sel, dvd_mag, hi_mag;
  logic [MAX_W-1:0] dvs_sel;
  int unsigned      w_bits;

  always_comb begin
    w_bits    = op_bits(32'(sz_i));
    dvd_sel   = dvd_ext[sz_i];
    dvs_sel   = dvs_ext[sz_i];
    dvd_neg_o = dvd_sel[DW-1];
    dvs_neg_o = dvs_sel[MAX_W-1];
    dvd_mag   = dvd_neg_o ? (DW'(0) - dvd_sel) : dvd_sel;
    dmag_o    = dvs_neg_o ? (MAX_W'(0) - dvs_sel) : dvs_sel;
    hi_mag    = dvd_mag >> w_bits;
    // magnitude quotient would need more than W bits (or divisor is zero)
    pre_err_o = hi_mag >= {{(DW-MAX_W){1'b0}}, dmag_o};
    r0_o      = pre_err_o ? '0 : hi_mag[MAX_W-1:0];
    q0_o      = dvd_mag[MAX_W-1:0] << (MAX_W - w_bits);
  end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int unsigned MAX_W = 64
) (
  input  logic [MAX_W-1:0] r_i,
  input  logic [MAX_W-1:0] q_i,
  input  logic [MAX_W-1:0] d_i,
  output logic [MAX_W-1:0] r_o,
  output logic [MAX_W-1:0] q_o
);
  logic [MAX_W:0]   trial;
  logic [MAX_W-1:0] diff;
  logic             ge;

  always_comb begin
    trial = {r_i, q_i[MAX_W-1]};
    ge    = trial >= {1'b0, d_i};
    diff  = trial[MAX_W-1:0] - d_i;
    r_o   = ge ? diff : trial[MAX_W-1:0];
    q_o   = {q_i[MAX_W-2:0], ge};
  end
endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix
  import sdiv_pkg::*;
#(
  parameter int unsigned NUM_SZ = 4,
  parameter int unsigned MAX_W  = 64,
  parameter int unsigned SZW    = 2
) (
  input  logic [SZW-1:0]   sz_i,
  input  logic [MAX_W-1:0] qmag_i,
  input  logic [MAX_W-1:0] rmag_i,
  input  logic             dvd_neg_i,
  input  logic             dvs_neg_i,
  input  logic             pre_err_i,
  output logic [MAX_W-1:0] quo_o,
  output logic [MAX_W-1:0] rem_o,
  output logic             err_o
);
  logic [MAX_W-1:0] q_sgn, r_sgn;
  logic [MAX_W-1:0] q_ext [NUM_SZ];
  logic [MAX_W-1:0] r_ext [NUM_SZ];
  logic [MAX_W:0]   lim;
  logic             neg_q, ovf;
  int unsigned      w_bits;

  always_comb begin
    w_bits = op_bits(32'(sz_i));
    neg_q  = dvd_neg_i ^ dvs_neg_i;
    lim    = {{MAX_W{1'b0}}, 1'b1} << (w_bits - 1);
    // negative side reaches 2^(W-1), positive side stops one short
    ovf    = neg_q ? ({1'b0, qmag_i} > lim) : ({1'b0, qmag_i} >= lim);
    q_sgn  = neg_q ? (MAX_W'(0) - qmag_i) : qmag_i;
    r_sgn  = dvd_neg_i ? (MAX_W'(0) - rmag_i) : rmag_i;
    err_o  = pre_err_i | ovf;
  end

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
    localparam int unsigned W = 8 << s;
    assign q_ext[s] = MAX_W'($signed(q_sgn[W-1:0]));
    assign r_ext[s] = MAX_W'($signed(r_sgn[W-1:0]));
  end

  assign quo_o = q_ext[sz_i];
  assign rem_o = r_ext[sz_i];
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
  import sdiv_pkg::*;
#(
  parameter int unsigned NUM_SZ = 4,
  localparam int unsigned SZW   = $clog2(NUM_SZ),
  localparam int unsigned MAX_W = 8 << (NUM_SZ - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SZW-1:0]   size_i,
  input  logic [MAX_W-1:0] dvd_hi_i,
  input  logic [MAX_W-1:0] dvd_lo_i,
  input  logic [MAX_W-1:0] dvs_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_err_o,
  output logic [MAX_W-1:0] quo_o,
  output logic [MAX_W-1:0] rem_o,
  output logic [15:0]      pack_o
);
  localparam int unsigned CW = $clog2(MAX_W);

  state_e           state_q;
  logic [CW-1:0]    cnt_q;
  logic [SZW-1:0]   sz_q;
  logic [MAX_W-1:0] r_q, q_q, d_q, quo_q, rem_q;
  logic             dvd_neg_q, dvs_neg_q, pre_err_q, done_q, err_q;

  logic [MAX_W-1:0] r0, q0, dmag, r_n, q_n, fix_quo, fix_rem;
  logic             dvd_neg, dvs_neg, pre_err, fix_err;

  sdiv_prep #(.NUM_SZ(NUM_SZ), .MAX_W(MAX_W), .SZW(SZW)) u_prep (
    .sz_i(size_i), .hi_i(dvd_hi_i), .lo_i(dvd_lo_i), .dvs_i(dvs_i),
    .r0_o(r0), .q0_o(q0), .dmag_o(dmag),
    .dvd_neg_o(dvd_neg), .dvs_neg_o(dvs_neg), .pre_err_o(pre_err)
  );

  sdiv_step #(.MAX_W(MAX_W)) u_step (
    .r_i(r_q), .q_i(q_q), .d_i(d_q), .r_o(r_n), .q_o(q_n)
  );

  sdiv_fix #(.NUM_SZ(NUM_SZ), .MAX_W(MAX_W), .SZW(SZW)) u_fix (
    .sz_i(sz_q), .qmag_i(q_q), .rmag_i(r_q),
    .dvd_neg_i(dvd_neg_q), .dvs_neg_i(dvs_neg_q), .pre_err_i(pre_err_q),
    .quo_o(fix_quo), .rem_o(fix_rem), .err_o(fix_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sz_q      <= '0;
      r_q       <= '0;
      q_q       <= '0;
      d_q       <= '0;
      dvd_neg_q <= 1'b0;
      dvs_neg_q <= 1'b0;
      pre_err_q <= 1'b0;
      quo_q     <= '0;
      rem_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sz_q      <= size_i;
            r_q       <= r0;
            q_q       <= q0;
            d_q       <= dmag;
            dvd_neg_q <= dvd_neg;
            dvs_neg_q <= dvs_neg;
            pre_err_q <= pre_err;
            cnt_q     <= CW'(op_bits(32'(size_i)) - 1);
            state_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          r_q <= r_n;
          q_q <= q_n;
          if (cnt_q == '0) state_q <= ST_FIX;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_FIX: begin
          done_q <= 1'b1;
          err_q  <= fix_err;
          if (!fix_err) begin
            quo_q <= fix_quo;
            rem_q <= fix_rem;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = state_q != ST_IDLE;
  assign done_o    = done_q;
  assign div_err_o = err_q;
  assign quo_o     = quo_q;
  assign rem_o     = rem_q;
  assign pack_o    = {rem_q[7:0], quo_q[7:0]};

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_err_with_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> done_o);
  assert_err_keeps_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> ($stable(quo_o) && $stable(rem_o)));
  assert_partial_rem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !pre_err_q) |-> (r_q < d_q));
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/sdiv_top_bench.sv
module sdiv_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  size = '0;
  logic [63:0] hi = '0, lo = '0, dv = '0;
  logic        busy, done, derr;
  logic [63:0] quo, rem;
  logic [15:0] pack;

  always #10 clk = ~clk;

  sdiv_top u_sdiv_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size),
    .dvd_hi_i(hi), .dvd_lo_i(lo), .dvs_i(dv),
    .busy_o(busy), .done_o(done), .div_err_o(derr),
    .quo_o(quo), .rem_o(rem), .pack_o(pack)
  );

  int checks = 0, fails = 0;

  // behavioural reference model
  logic        m_busy = 1'b0, m_done = 1'b0, m_err = 1'b0, p_err = 1'b0;
  int          m_cnt = 0;
  logic [63:0] m_quo = '0, m_rem = '0, p_quo = '0, p_rem = '0;

  function automatic void ref_div(input logic [1:0] s, input logic [63:0] h, l, d,
                                  output logic e, output logic [63:0] q, output logic [63:0] r);
    int unsigned w;
    logic [127:0] msk, j;
    logic [63:0]  dm;
    logic signed [129:0] dd, ds, qq, rr, up, dn;
    w   = 8 << s;
    msk = (128'd1 << w) - 128'd1;                 // R1: bits at or above W ignored
    j   = ((({64'd0, h}) & msk) << w) | ({64'd0, l} & msk);
    dd  = $signed({2'b00, j});
    if (j[2*w-1]) dd = dd - (130'sd1 <<< (2*w));
    dm  = d & 64'((msk[63:0]));
    ds  = $signed({66'd0, dm});
    if (dm[w-1]) ds = ds - (130'sd1 <<< w);
    e = 1'b0; q = '0; r = '0;
    if (ds == 0) e = 1'b1;                         // R5
    else begin
      qq = dd / ds;                                // R2 truncation toward zero
      rr = dd % ds;                                // R3 sign of dividend
      up = (130'sd1 <<< (w - 1)) - 130'sd1;
      dn = -(130'sd1 <<< (w - 1));
      if (qq > up || qq < dn) e = 1'b1;            // R4
      else begin
        q = qq[63:0];                              // R10 sign extension
        r = rr[63:0];
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_err = 1'b0; m_cnt = 0;
      m_quo = '0; m_rem = '0;
    end else begin
      m_done = 1'b0;
      m_err  = 1'b0;
      if (m_busy) begin                            // R8: start ignored here
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
          m_err  = p_err;
          if (!p_err) begin m_quo = p_quo; m_rem = p_rem; end
        end
      end else if (start) begin
        ref_div(size, hi, lo, dv, p_err, p_quo, p_rem);
        m_busy = 1'b1;
        m_cnt  = (8 << size) + 1;                  // R7 latency W+1
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check({busy, done, derr} == {m_busy, m_done, m_err}, "R7 handshake busy/done/err",
            64'({busy, done, derr}), 64'({m_busy, m_done, m_err}));
      if (m_done) begin
        check(quo == m_quo, "R2 quotient", quo, m_quo);
        check(rem == m_rem, "R3 remainder", rem, m_rem);
        check(derr == m_err, "R4 R5 divide error", 64'(derr), 64'(m_err));
        check(pack == {m_rem[7:0], m_quo[7:0]}, "R6 packed word", 64'(pack),
              64'({m_rem[7:0], m_quo[7:0]}));
      end
    end
  end

  task automatic op(input logic [1:0] s, input logic [63:0] h, l, d);
    @(negedge clk);
    size = s; hi = h; lo = l; dv = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy || m_done) @(negedge clk);
  endtask

  // R8: second request raised while busy with different operands
  task automatic op_interrupted(input logic [1:0] s, input logic [63:0] h, l, d);
    @(negedge clk);
    size = s; hi = h; lo = l; dv = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    hi = 64'h0; lo = 64'h55; dv = 64'h3; size = 2'd0; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    while (m_busy || m_done) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check({busy, done, derr} == 3'b000, "R9 reset flags", 64'({busy, done, derr}), 64'd0);
        check(quo == '0 && rem == '0 && pack == '0, "R9 reset results", quo | rem, 64'd0);
        rst_n = 1'b1;
        // R1 R2 R3 R6 R10: 8-bit sign combinations
        op(2'd0, 64'h00, 64'h64, 64'h07);
        op(2'd0, 64'hFF, 64'h9C, 64'h07);
        op(2'd0, 64'h00, 64'h64, 64'hF9);
        op(2'd0, 64'hFF, 64'h9C, 64'hF9);
        // R4: 8-bit range boundaries
        op(2'd0, 64'hFF, 64'h80, 64'h01);
        op(2'd0, 64'h00, 64'h80, 64'h01);
        op(2'd0, 64'hFF, 64'h80, 64'hFF);
        op(2'd0, 64'h00, 64'h7F, 64'h01);
        // R5: zero divisor with junk above W
        op(2'd0, 64'h1234_0000_0000_0000, 64'h10, 64'hFFFF_FF00);
        // R4: 16-bit boundaries
        op(2'd1, 64'h0001, 64'h0000, 64'h0002);
        op(2'd1, 64'hFFFF, 64'h0000, 64'h0002);
        // R1: 32-bit
        op(2'd2, 64'h0000_0000, 64'hDEAD_BEEF, 64'h0001_2345);
        op(2'd2, 64'hFFFF_FFFF, 64'h8000_0000, 64'hFFFF_FFFF);
        // R1 R2 R3: 64-bit sign combinations and limits
        op(2'd3, 64'h0, 64'd100, 64'd7);
        op(2'd3, '1, -64'sd100, 64'd7);
        op(2'd3, 64'h0, 64'd100, -64'sd7);
        op(2'd3, '1, -64'sd100, -64'sd7);
        op(2'd3, 64'h3FFF_FFFF_FFFF_FFFF, '1, 64'h7FFF_FFFF_FFFF_FFFF);
        op(2'd3, 64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000);
        op(2'd3, 64'h0, 64'h5, 64'h0);
        // R8
        op_interrupted(2'd3, 64'h0, 64'd1000, 64'd9);
        op_interrupted(2'd1, 64'h0, 64'h7000, 64'h0013);
        // mixed random operands, junk in unused bits
        for (int i = 0; i < 48; i++) begin
          logic [1:0]  s;
          logic [63:0] l, h, d;
          s = 2'($urandom_range(0, 3));
          l = {$urandom, $urandom};
          d = {$urandom, $urandom};
          if (i % 3 == 0) h = {$urandom, $urandom};
          else begin
            h = {$urandom, $urandom};
            h[(8 << s) - 1 -: 8] = l[(8 << s) - 1] ? 8'hFF : 8'h00;
            for (int b = 0; b < 64; b++) if (b < (8 << s)) h[b] = l[(8 << s) - 1];
          end
          if (i % 4 == 1) d = d >> 40;
          op(s, h, l, d);
        end
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule